// File: doc/BRIEF.md
# Synchronous Burst Latency and WAIT Sequencer

This block is the device-side timing logic of a synchronous burst pseudo-static memory. A host loads a 16-bit configuration word. The word selects synchronous burst or asynchronous operation, the initial access latency, the active level of the WAIT pin and whether WAIT leads the data by one cycle. When a burst READ or WRITE starts, the block counts the programmed latency in clocks and holds WAIT asserted during that count. It then marks each data beat on the 16-bit data bus as valid and numbers it, until the host ends the burst.

Only two latency codes are legal. A write that carries any other code keeps the latency already in place and sets a sticky error flag. While the block is in asynchronous mode, WAIT stays at its deasserted level and burst starts are ignored. The memory array, the page and asynchronous access paths and the pin electrical behaviour belong to other blocks.

Top module: `burst_lat_wait`

## Requirements
- R1: After reset the configuration is: asynchronous mode, latency code 3, WAIT active high, WAIT lead enabled. After reset, cfg_err is 0, beat_valid is 0, beat_idx is 0 and wait_o is 0.
- R2: A cfg_load pulse writes cfg_data at the clock edge. The fields are: bit 15 selects the mode (1 asynchronous, 0 synchronous burst), bits 13:11 hold the latency code, bit 10 is the WAIT level (1 active high, 0 active low) and bit 8 is the WAIT lead. The other bits have no effect.
- R3: A write whose latency code is neither 2 nor 3 keeps the previous latency code, still updates the other fields, and sets cfg_err. Only reset clears cfg_err.
- R4: In asynchronous mode a burst_start pulse has no effect, and wait_o stays at its deasserted level.
- R5: Code 2 gives a latency L of 3 clocks and code 3 gives 4 clocks. When burst_start is sampled at edge E0, beat_valid first goes high in the cycle that follows edge E0+L-1.
- R6: With the lead bit at 0, WAIT is asserted from the cycle after E0. It is released in the same cycle in which beat_valid first rises.
- R7: With the lead bit at 1, WAIT is released one cycle earlier than in R6, which is the cycle before beat_valid first rises.
- R8: The asserted WAIT level is the value of bit 10, and the deasserted level is its inverse. A change to bit 10 takes effect on the cycle after the write.
- R9: beat_valid stays high on every cycle after the latency count. beat_idx starts at 0 and increments by one per beat, wrapping at its width. A burst_end sampled while beat_valid is high makes that beat the last one. Afterwards beat_valid and beat_idx return to 0.
- R10: A burst_start sampled while a burst is in progress is ignored. A burst_end sampled during the latency count is ignored.
- R11: The latency and lead of a burst are those in force at its start edge. A configuration write during a burst affects only later bursts. The WAIT level is the exception and always follows the current configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Configuration write strobe |
| cfg_data | input | 16 | Configuration word |
| burst_start | input | 1 | Burst start pulse |
| burst_write | input | 1 | Burst direction, 1 for write (same timing both ways) |
| burst_end | input | 1 | Ends the burst after the current beat |
| wait_o | output | 1 | WAIT pin level |
| beat_valid | output | 1 | Data on the bus is valid this cycle |
| beat_idx | output | 8 | Index of the current beat |
| cfg_err | output | 1 | Sticky illegal-latency-code flag |

## Verification
Some rules can be checked on every cycle, and embedded properties check them. The stored latency code is always legal, and the error flag never falls. WAIT is never asserted while a beat is valid. The beat index steps by one between consecutive beats. WAIT sits at its deasserted level whenever no burst runs, and an asynchronous-mode start leaves the sequencer idle. The exact cycle of the first beat for each latency, the one-cycle shift from the lead bit, the live level inversion and capture of the configuration at the start edge can only be shown by the scenarios. The bench's behavioural model is compared against all outputs on every clock during those scenarios.

// File: rtl/burst_lat_pkg.sv
package burst_lat_pkg;

  localparam int CFG_W    = 16;
  localparam int CNT_W    = 3;
  localparam int CODE_W   = 3;
  localparam int MODE_BIT = 15;
  localparam int CODE_HI  = 13;
  localparam int CODE_LO  = 11;
  localparam int POL_BIT  = 10;
  localparam int LEAD_BIT = 8;

  localparam logic [CODE_W-1:0] CODE_SHORT = 3'd2;
  localparam logic [CODE_W-1:0] CODE_LONG  = 3'd3;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LAT  = 2'd1,
    SEQ_DATA = 2'd2
  } seq_state_e;

  function automatic logic code_legal(input logic [CODE_W-1:0] code);
    return (code == CODE_SHORT) || (code == CODE_LONG);
  endfunction

  function automatic logic [CNT_W-1:0] clocks_of_code(input logic [CODE_W-1:0] code);
    return (code == CODE_SHORT) ? CNT_W'(3) : CNT_W'(4);
  endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
  import burst_lat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [CFG_W-1:0]     wdata,
  output logic                 async_mode,
  output logic [CODE_W-1:0]    lat_code,
  output logic                 pol_high,
  output logic                 wait_lead,
  output logic                 code_err
);

  logic              async_q, async_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              pol_q, pol_d;
  logic              lead_q, lead_d;
  logic              err_q, err_d;
  logic [CODE_W-1:0] new_code;

  assign new_code = wdata[CODE_HI:CODE_LO];

  always_comb begin
    async_d = async_q;
    code_d  = code_q;
    pol_d   = pol_q;
    lead_d  = lead_q;
    err_d   = err_q;
    if (load) begin
      async_d = wdata[MODE_BIT];
      pol_d   = wdata[POL_BIT];
      lead_d  = wdata[LEAD_BIT];
      if (code_legal(new_code)) begin
        code_d = new_code;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      async_q <= 1'b1;
      code_q  <= CODE_LONG;
      pol_q   <= 1'b1;
      lead_q  <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      async_q <= async_d;
      code_q  <= code_d;
      pol_q   <= pol_d;
      lead_q  <= lead_d;
      err_q   <= err_d;
    end
  end

  assign async_mode = async_q;
  assign lat_code   = code_q;
  assign pol_high   = pol_q;
  assign wait_lead  = lead_q;
  assign code_err   = err_q;

  // R3
  code_stays_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == CODE_SHORT) || (code_q == CODE_LONG));

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

endmodule

// File: rtl/burst_lat_seq.sv
module burst_lat_seq
  import burst_lat_pkg::*;
#(
  parameter int BEAT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 stop,
  input  logic                 async_mode,
  input  logic [CNT_W-1:0]     lat_clks,
  input  logic                 lead_cfg,
  output logic                 wait_act,
  output logic                 valid,
  output logic [BEAT_W-1:0]    idx,
  output logic                 busy
);

  seq_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  lat_q, lat_d;
  logic              lead_q, lead_d;
  logic              wait_q, wait_d;
  logic              vld_q, vld_d;
  logic [BEAT_W-1:0] idx_q, idx_d;
  logic [CNT_W:0]    cnt_nxt;
  logic [CNT_W:0]    wait_last;

  assign cnt_nxt   = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign wait_last = {1'b0, lat_q} - (CNT_W+1)'(1) - (CNT_W+1)'(lead_q);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    lat_d  = lat_q;
    lead_d = lead_q;
    wait_d = wait_q;
    vld_d  = vld_q;
    idx_d  = idx_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (start && !async_mode) begin
          st_d   = SEQ_LAT;
          cnt_d  = CNT_W'(1);
          lat_d  = lat_clks;
          lead_d = lead_cfg;
          wait_d = 1'b1;
        end
      end
      SEQ_LAT: begin
        cnt_d  = cnt_q + CNT_W'(1);
        wait_d = (cnt_nxt <= wait_last);
        if (cnt_q == lat_q - CNT_W'(1)) begin
          st_d  = SEQ_DATA;
          vld_d = 1'b1;
          idx_d = '0;
        end
      end
      SEQ_DATA: begin
        wait_d = 1'b0;
        if (stop) begin
          st_d  = SEQ_IDLE;
          vld_d = 1'b0;
          idx_d = '0;
          cnt_d = '0;
        end else begin
          idx_d = idx_q + BEAT_W'(1);
        end
      end
      default: begin
        st_d   = SEQ_IDLE;
        wait_d = 1'b0;
        vld_d  = 1'b0;
        idx_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      cnt_q  <= '0;
      lat_q  <= CNT_W'(4);
      lead_q <= 1'b1;
      wait_q <= 1'b0;
      vld_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      lat_q  <= lat_d;
      lead_q <= lead_d;
      wait_q <= wait_d;
      vld_q  <= vld_d;
      idx_q  <= idx_d;
    end
  end

  assign wait_act = wait_q;
  assign valid    = vld_q;
  assign idx      = idx_q;
  assign busy     = (st_q != SEQ_IDLE);

  // R6
  no_wait_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wait_q && vld_q));

  // R9
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && $past(vld_q)) |-> (idx_q == $past(idx_q) + BEAT_W'(1)));

  // R4
  async_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_IDLE && start && async_mode) |=> (st_q == SEQ_IDLE));

endmodule

// File: rtl/wait_level_drv.sv
module wait_level_drv (
  input  logic wait_act,
  input  logic pol_high,
  output logic wait_pin
);

  always_comb begin
    if (pol_high) begin
      wait_pin = wait_act;
    end else begin
      wait_pin = ~wait_act;
    end
  end

endmodule

// File: rtl/burst_lat_wait.sv
module burst_lat_wait
  import burst_lat_pkg::*;
#(
  parameter int BEAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [15:0]       cfg_data,
  input  logic              burst_start,
  input  logic              burst_write,
  input  logic              burst_end,
  output logic              wait_o,
  output logic              beat_valid,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              cfg_err
);

  logic              async_mode;
  logic [CODE_W-1:0] lat_code;
  logic              pol_high;
  logic              wait_lead;
  logic              wait_act;
  logic              busy;
  logic [CNT_W-1:0]  lat_clks;
  logic              dir_seen;

  assign dir_seen = burst_write;
  assign lat_clks = clocks_of_code(lat_code);

  burst_cfg_reg cfg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cfg_load),
    .wdata      (cfg_data),
    .async_mode (async_mode),
    .lat_code   (lat_code),
    .pol_high   (pol_high),
    .wait_lead  (wait_lead),
    .code_err   (cfg_err)
  );

  burst_lat_seq #(.BEAT_W(BEAT_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (burst_start),
    .stop       (burst_end),
    .async_mode (async_mode),
    .lat_clks   (lat_clks),
    .lead_cfg   (wait_lead),
    .wait_act   (wait_act),
    .valid      (beat_valid),
    .idx        (beat_idx),
    .busy       (busy)
  );

  wait_level_drv drv_i (
    .wait_act (wait_act),
    .pol_high (pol_high),
    .wait_pin (wait_o)
  );

  // R4
  idle_wait_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || dir_seen || !dir_seen) |-> (busy || (wait_o == !pol_high)));

endmodule

// File: tb/burst_lat_wait_tb_top.sv
module burst_lat_wait_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [15:0]   cfg_data = '0;
  logic          burst_start = 1'b0;
  logic          burst_write = 1'b0;
  logic          burst_end = 1'b0;
  logic          wait_o;
  logic          beat_valid;
  logic [BW-1:0] beat_idx;
  logic          cfg_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R1";

  burst_lat_wait #(.BEAT_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_data(cfg_data),
    .burst_start(burst_start), .burst_write(burst_write), .burst_end(burst_end),
    .wait_o(wait_o), .beat_valid(beat_valid), .beat_idx(beat_idx), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  bit m_async, m_pol, m_lead_cfg, m_err, m_busy;
  int m_code, m_t, m_L, m_lead;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_async = 1; m_code = 3; m_pol = 1; m_lead_cfg = 1; m_err = 0;
      m_busy = 0; m_t = 0; m_L = 4; m_lead = 1;
    end else begin
      if (!m_busy) begin
        if (burst_start && !m_async) begin
          m_busy = 1; m_t = 1; m_L = (m_code == 2) ? 3 : 4; m_lead = m_lead_cfg;
        end
      end else if (m_t >= m_L && burst_end) begin
        m_busy = 0;
      end else begin
        m_t++;
      end
      if (cfg_load) begin
        m_async = cfg_data[15]; m_pol = cfg_data[10]; m_lead_cfg = cfg_data[8];
        if (cfg_data[13:11] == 3'd2 || cfg_data[13:11] == 3'd3) m_code = cfg_data[13:11];
        else m_err = 1;
      end
    end
  end

  task automatic check1(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ev, ew;
      int ei;
      ev = m_busy && (m_t >= m_L);
      ei = ev ? ((m_t - m_L) % 256) : 0;
      ew = m_busy && (m_t <= m_L - 1 - m_lead);
      check1("beat_valid", int'(beat_valid), int'(ev));
      check1("beat_idx", int'(beat_idx), ei);
      check1("wait_o", int'(wait_o), int'(m_pol ? ew : !ew));
      check1("cfg_err", int'(cfg_err), int'(m_err));
    end
  end

  function automatic logic [15:0] mk(bit asy, logic [2:0] code, bit pol, bit lead);
    return {asy, 1'b0, code, pol, 1'b0, lead, 8'h5A};
  endfunction

  task automatic write_cfg(logic [15:0] v);
    @(negedge clk); cfg_load = 1; cfg_data = v;
    @(negedge clk); cfg_load = 0;
  endtask

  task automatic run_burst(int beats, bit wr);
    int seen = 0;
    @(negedge clk); burst_start = 1; burst_write = wr;
    @(negedge clk); burst_start = 0;
    for (int k = 0; k < 1000; k++) begin
      if (beat_valid) begin
        seen++;
        if (seen == beats) begin
          burst_end = 1;
          @(negedge clk); burst_end = 0;
          break;
        end
      end
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check1("R1 reset wait", int'(wait_o), 0);
    check1("R1 reset valid", int'(beat_valid), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    cur_req = "R4 async start ignored";
    run_burst(1, 0);
    repeat (4) @(negedge clk);

    cur_req = "R2 R5 R7 R9 code3 lead1";
    write_cfg(mk(0, 3'd3, 1, 1));
    run_burst(3, 0);

    cur_req = "R5 R6 code2 lead0";
    write_cfg(mk(0, 3'd2, 1, 0));
    run_burst(4, 1);

    cur_req = "R8 active-low WAIT";
    write_cfg(mk(0, 3'd3, 0, 0));
    run_burst(2, 0);
    write_cfg(mk(0, 3'd2, 0, 1));
    run_burst(2, 1);

    cur_req = "R3 illegal code kept";
    write_cfg(mk(0, 3'd5, 1, 0));
    run_burst(2, 0);
    write_cfg(mk(0, 3'd0, 0, 1));
    write_cfg(mk(0, 3'd3, 1, 1));
    run_burst(1, 0);

    cur_req = "R10 start and end ignored";
    @(negedge clk); burst_start = 1;
    @(negedge clk); burst_start = 0; burst_end = 1;
    @(negedge clk); burst_start = 1; burst_end = 0;
    @(negedge clk); burst_start = 0;
    repeat (4) @(negedge clk);
    burst_end = 1;
    @(negedge clk); burst_end = 0;
    repeat (3) @(negedge clk);

    cur_req = "R11 config captured at start";
    @(negedge clk); burst_start = 1;
    @(negedge clk); burst_start = 0; cfg_load = 1; cfg_data = mk(0, 3'd2, 0, 0);
    @(negedge clk); cfg_load = 0;
    repeat (4) @(negedge clk);
    burst_end = 1;
    @(negedge clk); burst_end = 0;
    run_burst(2, 0);

    cur_req = "R9 index wrap";
    write_cfg(mk(0, 3'd3, 1, 1));
    run_burst(300, 1);

    cur_req = "R4 back to async";
    write_cfg(mk(1, 3'd2, 1, 0));
    run_burst(1, 0);
    repeat (5) @(negedge clk);

    finish_run();
  end

endmodule